// File: doc/BRIEF.md
# Quad Wiper Register Command Decoder

This block sits behind a serial front end that has already turned the serial line into received bytes and per-clock bit strobes. It interprets the command stream for a device with four channels. Each channel has a 6-bit wiper code that selects one of 64 taps, and four stored settings. A select window opens with a device byte and continues with an instruction byte. Depending on the opcode, the window then carries one data byte, nothing more, or a run of single-bit stepping pulses.

The block keeps the four live wiper codes and a mirror of the sixteen stored settings. Commands move values in several ways:
- between the host and a wiper code or a stored setting;
- between a wiper and one of its own stored settings;
- across all four channels at once.

Anything that changes a stored setting is staged during the window. When the select line falls, the staged change is handed to an external write-cycle controller as a one-cycle request. The mirror takes the new value at that same moment. Read results and the write-busy status come back as a byte for the front end to shift out.

Top module: `quad_wiper_decoder`

## Requirements
- R1: After reset all four wiper codes are 0, all stored settings are 0, and `tx_load` and `nv_req` are low.
- R2: The first byte of a select window must equal {0101, 00, dev_addr}. Any other value makes the block ignore the rest of the window: no wiper, stored setting, read or request changes.
- R3: The instruction byte has the layout opcode[7:4], slot[3:2], channel[1:0]. Opcode 1010 followed by a data byte loads data[5:0] into the channel's wiper code, and bits 7:6 of the data byte are ignored.
- R4: Opcode 1001 returns that channel's wiper code and opcode 1011 returns the stored setting (channel, slot). Each read gives a single `tx_load` pulse with `tx_byte` = {00, value}.
- R5: Opcode 1100 plus a data byte, and opcode 1110 (wiper to stored setting), stage a write without changing the stored value. When `sel` falls, `nv_req` pulses once with a one-hot channel in `nv_mask`, the slot in `nv_slot` and the value in `nv_data[6c+5:6c]`, and a read afterwards returns the new value.
- R6: Opcode 1101 copies stored setting (channel, slot) into that channel's wiper code.
- R7: With channel field 00, opcode 0001 loads every wiper code from its own stored setting in the given slot. Opcode 1000 stages every wiper code into that slot, which gives `nv_mask` = 1111 at `sel` fall. With a nonzero channel field both are ignored.
- R8: The instruction byte 0101_0001 returns {0000000, wip}.
- R9: After opcode 0010, each `bit_vld` pulse moves the chosen wiper one step: up when `bit_in` = 1, down when it is 0. The code saturates at 63 and 0, and the mode ends when `sel` falls.
- R10: Unknown opcodes, and any byte after a command is complete, are ignored until `sel` falls.
- R11: `nv_req` lasts exactly one cycle for each window that staged a write, and a window with no staged write produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_addr | input | 2 | Strapped address of this device |
| sel | input | 1 | High while the select window is open |
| byte_vld | input | 1 | One-cycle strobe: a whole byte has been received |
| byte_in | input | 8 | Received byte |
| bit_vld | input | 1 | One-cycle strobe per serial clock, used in stepping mode |
| bit_in | input | 1 | Serial data level captured with `bit_vld` |
| wip | input | 1 | Write-cycle controller busy flag |
| wiper_code | output | 24 | Four 6-bit tap selects, channel c at [6c+5:6c] |
| tx_load | output | 1 | One-cycle strobe: `tx_byte` holds a read result |
| tx_byte | output | 8 | Read result for the front end to shift out |
| nv_req | output | 1 | One-cycle write request to the write-cycle controller |
| nv_mask | output | 4 | Channels covered by the request |
| nv_slot | output | 2 | Stored-setting slot of the request |
| nv_data | output | 24 | Values to store, channel c at [6c+5:6c] |

## Verification
On every cycle, assertions check the following:
- a mismatched device byte never advances to instruction decode;
- each window executes at most one command;
- a step at either end of the range holds the code;
- a request is a lone pulse with a non-empty mask that follows a select fall;
- read bytes have zero upper bits.

Only the bench scenarios show that values end up in the right channel and slot. They also show that a staged write stays invisible until `sel` falls, that transfers and the all-channel commands move the right data, and that ignored or malformed windows leave every output unchanged.

// File: rtl/qwd_pkg.sv
package qwd_pkg;

    typedef enum logic [2:0] {
        ST_DEV,
        ST_INS,
        ST_DAT,
        ST_STEP,
        ST_SKIP
    } fsm_e;

    typedef enum logic [3:0] {
        K_NONE,
        K_RD_WCR,
        K_WR_WCR,
        K_RD_DR,
        K_WR_DR,
        K_XDW,
        K_XWD,
        K_GDW,
        K_GWD,
        K_STAT
    } kind_e;

    localparam logic [3:0] DEV_ID    = 4'b0101;
    localparam logic [3:0] OP_RD_WCR = 4'b1001;
    localparam logic [3:0] OP_WR_WCR = 4'b1010;
    localparam logic [3:0] OP_RD_DR  = 4'b1011;
    localparam logic [3:0] OP_WR_DR  = 4'b1100;
    localparam logic [3:0] OP_XDW    = 4'b1101;
    localparam logic [3:0] OP_XWD    = 4'b1110;
    localparam logic [3:0] OP_GDW    = 4'b0001;
    localparam logic [3:0] OP_GWD    = 4'b1000;
    localparam logic [3:0] OP_STEP   = 4'b0010;
    localparam logic [3:0] OP_STAT   = 4'b0101;
    localparam logic [3:0] STAT_LOW  = 4'b0001;

endpackage

// File: rtl/qwd_cmd_fsm.sv
module qwd_cmd_fsm
    import qwd_pkg::*;
#(
    parameter int CHW = 2,
    parameter int SLW = 2,
    parameter int WW  = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     dev_addr,
    input  logic           sel,
    input  logic           byte_vld,
    input  logic [7:0]     byte_in,
    output logic           exec,
    output kind_e          kind,
    output logic [CHW-1:0] chan,
    output logic [SLW-1:0] slot,
    output logic [WW-1:0]  data,
    output logic           step_mode
);

    typedef struct packed {
        fsm_e           st;
        kind_e          kind;
        logic           exec;
        logic [CHW-1:0] chan;
        logic [SLW-1:0] slot;
        logic [WW-1:0]  data;
    } fsm_t;

    fsm_t q, d;

    logic [3:0] op;
    assign op = byte_in[7:4];

    always_comb begin
        d      = q;
        d.exec = 1'b0;
        if (!sel) begin
            d.st = ST_DEV;
        end else if (byte_vld) begin
            case (q.st)
                ST_DEV: begin
                    if (byte_in == {DEV_ID, 2'b00, dev_addr}) d.st = ST_INS;
                    else                                      d.st = ST_SKIP;
                end
                ST_INS: begin
                    d.chan = byte_in[CHW-1:0];
                    d.slot = byte_in[2 +: SLW];
                    d.st   = ST_SKIP;
                    d.kind = K_NONE;
                    case (op)
                        OP_RD_WCR: begin d.kind = K_RD_WCR; d.exec = 1'b1; end
                        OP_WR_WCR: begin d.kind = K_WR_WCR; d.st = ST_DAT; end
                        OP_RD_DR:  begin d.kind = K_RD_DR;  d.exec = 1'b1; end
                        OP_WR_DR:  begin d.kind = K_WR_DR;  d.st = ST_DAT; end
                        OP_XDW:    begin d.kind = K_XDW;    d.exec = 1'b1; end
                        OP_XWD:    begin d.kind = K_XWD;    d.exec = 1'b1; end
                        OP_GDW: if (byte_in[1:0] == 2'b00) begin
                            d.kind = K_GDW; d.exec = 1'b1;
                        end
                        OP_GWD: if (byte_in[1:0] == 2'b00) begin
                            d.kind = K_GWD; d.exec = 1'b1;
                        end
                        OP_STAT: if (byte_in[3:0] == STAT_LOW) begin
                            d.kind = K_STAT; d.exec = 1'b1;
                        end
                        OP_STEP:   d.st = ST_STEP;
                        default:   d.st = ST_SKIP;
                    endcase
                end
                ST_DAT: begin
                    d.data = byte_in[WW-1:0];
                    d.exec = 1'b1;
                    d.st   = ST_SKIP;
                end
                default: d.st = q.st;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_DEV, kind: K_NONE, exec: 1'b0,
                   chan: '0, slot: '0, data: '0};
        end else begin
            q <= d;
        end
    end

    assign exec      = q.exec;
    assign kind      = q.kind;
    assign chan      = q.chan;
    assign slot      = q.slot;
    assign data      = q.data;
    assign step_mode = (q.st == ST_STEP) && sel;

    // R2
    bad_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DEV && sel && byte_vld && byte_in[1:0] != dev_addr)
        |=> q.st != ST_INS);

    // R10
    one_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec |=> !exec);

endmodule

// File: rtl/qwd_wiper_bank.sv
module qwd_wiper_bank #(
    parameter int NCH = 4,
    parameter int WW  = 6,
    parameter int CHW = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_one,
    input  logic [CHW-1:0]            one_ch,
    input  logic [WW-1:0]             one_val,
    input  logic                      load_all,
    input  logic [NCH-1:0][WW-1:0]    all_val,
    input  logic                      step_en,
    input  logic [CHW-1:0]            step_ch,
    input  logic                      step_up,
    output logic [NCH-1:0][WW-1:0]    wcr
);

    localparam logic [WW-1:0] TOP = {WW{1'b1}};

    typedef struct packed {
        logic [NCH-1:0][WW-1:0] wcr;
    } bank_t;

    bank_t q, d;

    always_comb begin
        d = q;
        if (load_all) begin
            d.wcr = all_val;
        end else if (load_one) begin
            d.wcr[one_ch] = one_val;
        end else if (step_en) begin
            if (step_up) begin
                if (q.wcr[step_ch] != TOP) d.wcr[step_ch] = q.wcr[step_ch] + 1'b1;
            end else begin
                if (q.wcr[step_ch] != '0) d.wcr[step_ch] = q.wcr[step_ch] - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wcr = q.wcr;

    // R9
    sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && step_up && !load_one && !load_all && wcr[step_ch] == TOP)
        |=> wcr[$past(step_ch)] == TOP);

    // R9
    sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !step_up && !load_one && !load_all && wcr[step_ch] == '0)
        |=> wcr[$past(step_ch)] == '0);

endmodule

// File: rtl/qwd_nv_bank.sv
module qwd_nv_bank #(
    parameter int NCH   = 4,
    parameter int NSLOT = 4,
    parameter int WW    = 6,
    parameter int CHW   = 2,
    parameter int SLW   = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               sel,
    input  logic                               stage_one,
    input  logic [CHW-1:0]                     one_ch,
    input  logic [WW-1:0]                      one_val,
    input  logic                               stage_all,
    input  logic [SLW-1:0]                     slot,
    input  logic [NCH-1:0][WW-1:0]             all_val,
    output logic [NCH-1:0][NSLOT-1:0][WW-1:0]  dr,
    output logic                               nv_req,
    output logic [NCH-1:0]                     nv_mask,
    output logic [SLW-1:0]                     nv_slot,
    output logic [NCH-1:0][WW-1:0]             nv_data
);

    typedef struct packed {
        logic                              sel;
        logic [NCH-1:0]                    pmask;
        logic [SLW-1:0]                    pslot;
        logic [NCH-1:0][WW-1:0]            pdata;
        logic                              req;
        logic [NCH-1:0]                    omask;
        logic [SLW-1:0]                    oslot;
        logic [NCH-1:0][WW-1:0]            odata;
        logic [NCH-1:0][NSLOT-1:0][WW-1:0] dr;
    } nv_t;

    nv_t q, d;

    always_comb begin
        d     = q;
        d.sel = sel;
        d.req = 1'b0;
        if (stage_all) begin
            d.pmask = '1;
            d.pslot = slot;
            d.pdata = all_val;
        end else if (stage_one) begin
            d.pmask         = '0;
            d.pmask[one_ch] = 1'b1;
            d.pslot         = slot;
            d.pdata[one_ch] = one_val;
        end
        if (q.sel && !sel) begin
            if (d.pmask != '0) begin
                d.req   = 1'b1;
                d.omask = d.pmask;
                d.oslot = d.pslot;
                d.odata = d.pdata;
                for (int c = 0; c < NCH; c++) begin
                    if (d.pmask[c]) d.dr[c][d.pslot] = d.pdata[c];
                end
            end
            d.pmask = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dr      = q.dr;
    assign nv_req  = q.req;
    assign nv_mask = q.omask;
    assign nv_slot = q.oslot;
    assign nv_data = q.odata;

    // R11
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_req |=> !nv_req);

    // R5
    req_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_req |-> nv_mask != '0);

    // R5
    req_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_req |-> !$past(sel));

endmodule

// File: rtl/quad_wiper_decoder.sv
module quad_wiper_decoder
    import qwd_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int NSLOT = 4,
    parameter int WW    = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             dev_addr,
    input  logic                   sel,
    input  logic                   byte_vld,
    input  logic [7:0]             byte_in,
    input  logic                   bit_vld,
    input  logic                   bit_in,
    input  logic                   wip,
    output logic [NCH*WW-1:0]      wiper_code,
    output logic                   tx_load,
    output logic [7:0]             tx_byte,
    output logic                   nv_req,
    output logic [NCH-1:0]         nv_mask,
    output logic [$clog2(NSLOT)-1:0] nv_slot,
    output logic [NCH*WW-1:0]      nv_data
);

    localparam int CHW = $clog2(NCH);
    localparam int SLW = $clog2(NSLOT);

    logic                              exec;
    kind_e                             kind;
    logic [CHW-1:0]                    chan;
    logic [SLW-1:0]                    slot;
    logic [WW-1:0]                     data;
    logic                              step_mode;
    logic [NCH-1:0][WW-1:0]            wcr;
    logic [NCH-1:0][NSLOT-1:0][WW-1:0] dr;
    logic [NCH-1:0][WW-1:0]            dr_slot;
    logic [NCH-1:0][WW-1:0]            nv_data_a;

    logic                              w_one;
    logic [WW-1:0]                     w_one_val;
    logic                              w_all;
    logic                              n_one;
    logic [WW-1:0]                     n_one_val;
    logic                              n_all;

    qwd_cmd_fsm #(.CHW(CHW), .SLW(SLW), .WW(WW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_addr  (dev_addr),
        .sel       (sel),
        .byte_vld  (byte_vld),
        .byte_in   (byte_in),
        .exec      (exec),
        .kind      (kind),
        .chan      (chan),
        .slot      (slot),
        .data      (data),
        .step_mode (step_mode)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_slot
            assign dr_slot[c] = dr[c][slot];
            assign wiper_code[c*WW +: WW] = wcr[c];
            assign nv_data[c*WW +: WW]    = nv_data_a[c];
        end
    endgenerate

    always_comb begin
        w_one     = 1'b0;
        w_one_val = data;
        w_all     = 1'b0;
        n_one     = 1'b0;
        n_one_val = data;
        n_all     = 1'b0;
        if (exec) begin
            case (kind)
                K_WR_WCR: w_one = 1'b1;
                K_XDW:    begin w_one = 1'b1; w_one_val = dr_slot[chan]; end
                K_GDW:    w_all = 1'b1;
                K_WR_DR:  n_one = 1'b1;
                K_XWD:    begin n_one = 1'b1; n_one_val = wcr[chan]; end
                K_GWD:    n_all = 1'b1;
                default:  ;
            endcase
        end
    end

    qwd_wiper_bank #(.NCH(NCH), .WW(WW), .CHW(CHW)) u_wipers (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_one (w_one),
        .one_ch   (chan),
        .one_val  (w_one_val),
        .load_all (w_all),
        .all_val  (dr_slot),
        .step_en  (step_mode && bit_vld),
        .step_ch  (chan),
        .step_up  (bit_in),
        .wcr      (wcr)
    );

    qwd_nv_bank #(.NCH(NCH), .NSLOT(NSLOT), .WW(WW), .CHW(CHW), .SLW(SLW)) u_nv (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .stage_one (n_one),
        .one_ch    (chan),
        .one_val   (n_one_val),
        .stage_all (n_all),
        .slot      (slot),
        .all_val   (wcr),
        .dr        (dr),
        .nv_req    (nv_req),
        .nv_mask   (nv_mask),
        .nv_slot   (nv_slot),
        .nv_data   (nv_data_a)
    );

    typedef struct packed {
        logic       load;
        logic [7:0] data;
    } tx_t;

    tx_t tx_q, tx_d;

    always_comb begin
        tx_d      = tx_q;
        tx_d.load = 1'b0;
        if (exec) begin
            case (kind)
                K_RD_WCR: begin tx_d.load = 1'b1; tx_d.data = 8'(wcr[chan]); end
                K_RD_DR:  begin tx_d.load = 1'b1; tx_d.data = 8'(dr_slot[chan]); end
                K_STAT:   begin tx_d.load = 1'b1; tx_d.data = 8'(wip); end
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign tx_load = tx_q.load;
    assign tx_byte = tx_q.data;

    // R4
    tx_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> (tx_byte >> WW) == 8'd0);

endmodule

// File: tb/quad_wiper_decoder_bench.sv
module quad_wiper_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  dev_addr = 2'b01;
    logic        sel = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic        bit_vld = 1'b0;
    logic        bit_in = 1'b0;
    logic        wip = 1'b0;
    logic [23:0] wiper_code;
    logic        tx_load;
    logic [7:0]  tx_byte;
    logic        nv_req;
    logic [3:0]  nv_mask;
    logic [1:0]  nv_slot;
    logic [23:0] nv_data;

    always #10 clk = ~clk;

    quad_wiper_decoder u_quad_wiper_decoder (
        .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr), .sel(sel),
        .byte_vld(byte_vld), .byte_in(byte_in), .bit_vld(bit_vld),
        .bit_in(bit_in), .wip(wip), .wiper_code(wiper_code),
        .tx_load(tx_load), .tx_byte(tx_byte), .nv_req(nv_req),
        .nv_mask(nv_mask), .nv_slot(nv_slot), .nv_data(nv_data)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;
    int tx_cnt = 0;
    int tx_last = 0;
    int nv_cnt = 0;
    int nv_m = 0;
    int nv_s = 0;
    logic [23:0] nv_d = '0;
    int ew [4];
    int edr [4][4];

    localparam logic [7:0] DEVB = 8'h51;

    always @(negedge clk) begin
        if (tx_load) begin tx_cnt++; tx_last = int'(tx_byte); end
        if (nv_req) begin nv_cnt++; nv_m = int'(nv_mask); nv_s = int'(nv_slot); nv_d = nv_data; end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_wipers(input string req);
        for (int c = 0; c < 4; c++) check(req, int'(wiper_code[c*6 +: 6]), ew[c]);
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); byte_vld = 1'b1; byte_in = b;
        @(negedge clk); byte_vld = 1'b0;
    endtask

    task automatic open_win();
        @(negedge clk); sel = 1'b1;
    endtask

    task automatic close_win();
        repeat (2) @(negedge clk);
        sel = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic cmd2(input logic [7:0] ins);
        open_win(); send(DEVB); send(ins); close_win();
    endtask

    task automatic cmd3(input logic [7:0] ins, input logic [7:0] dat);
        open_win(); send(DEVB); send(ins); send(dat); close_win();
    endtask

    task automatic step(input logic up);
        @(negedge clk); bit_vld = 1'b1; bit_in = up;
        @(negedge clk); bit_vld = 1'b0;
    endtask

    function automatic logic [7:0] ins(input logic [3:0] op, input int s, input int c);
        return {op, 2'(s), 2'(c)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int t0;
        int n0;
        for (int c = 0; c < 4; c++) begin
            ew[c] = 0;
            for (int s = 0; s < 4; s++) edr[c][s] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_wipers("R1");
        check("R1 tx_load", int'(tx_load), 0);
        check("R1 nv_req", int'(nv_req), 0);

        // R3 sweep every code on every channel
        for (int c = 0; c < 4; c++) begin
            for (int v = 0; v < 64; v++) begin
                cmd3(ins(4'b1010, 0, c), 8'(v));
                ew[c] = v;
                check_wipers("R3");
            end
        end
        // R3 upper data bits ignored
        cmd3(ins(4'b1010, 2, 1), 8'hC5);
        ew[1] = 5;
        check_wipers("R3 upper bits");

        // R4 read each wiper
        for (int c = 0; c < 4; c++) begin
            cmd3(ins(4'b1010, 0, c), 8'(10 + c * 7));
            ew[c] = 10 + c * 7;
            t0 = tx_cnt;
            cmd2(ins(4'b1001, 0, c));
            check("R4 wcr read count", tx_cnt - t0, 1);
            check("R4 wcr read value", tx_last, ew[c]);
        end

        // R2 wrong address and wrong device type
        t0 = tx_cnt;
        open_win(); send(8'h52); send(ins(4'b1010, 0, 0)); send(8'd33); close_win();
        open_win(); send(8'h71); send(ins(4'b1010, 0, 0)); send(8'd33); close_win();
        open_win(); send(8'h50); send(ins(4'b1001, 0, 0)); close_win();
        check_wipers("R2");
        check("R2 no read", tx_cnt - t0, 0);

        // R5 staged write invisible until sel falls
        n0 = nv_cnt;
        open_win(); send(DEVB); send(ins(4'b1100, 3, 2)); send(8'h2A);
        repeat (3) @(negedge clk);
        check("R5 no req while selected", nv_cnt - n0, 0);
        sel = 1'b0;
        repeat (3) @(negedge clk);
        edr[2][3] = 42;
        check("R5 req count", nv_cnt - n0, 1);
        check("R5 mask", nv_m, 4);
        check("R5 slot", nv_s, 3);
        check("R5 data", int'(nv_d[12 +: 6]), 42);

        // R5 sweep all channels and slots, then read back
        for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 4; s++) begin
                n0 = nv_cnt;
                edr[c][s] = (c * 16 + s * 4 + 5) & 63;
                cmd3(ins(4'b1100, s, c), 8'(edr[c][s]));
                check("R5 sweep mask", nv_m, 1 << c);
                check("R11 one pulse", nv_cnt - n0, 1);
            end
        end
        for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 4; s++) begin
                cmd2(ins(4'b1011, s, c));
                check("R4 dr read", tx_last, edr[c][s]);
            end
        end

        // R11 read-only window makes no request
        n0 = nv_cnt;
        cmd2(ins(4'b1001, 0, 3));
        check("R11 no request", nv_cnt - n0, 0);

        // R5 wiper to stored setting
        cmd3(ins(4'b1010, 0, 3), 8'd50);
        ew[3] = 50;
        cmd2(ins(4'b1110, 1, 3));
        edr[3][1] = 50;
        check("R5 xfer mask", nv_m, 8);
        check("R5 xfer data", int'(nv_d[18 +: 6]), 50);
        cmd2(ins(4'b1011, 1, 3));
        check("R5 xfer readback", tx_last, 50);

        // R6 stored setting to wiper
        for (int c = 0; c < 4; c++) begin
            cmd2(ins(4'b1101, 2, c));
            ew[c] = edr[c][2];
            check_wipers("R6");
        end

        // R7 global load from slot 1
        cmd2(ins(4'b0001, 1, 0));
        for (int c = 0; c < 4; c++) ew[c] = edr[c][1];
        check_wipers("R7 global load");
        // R7 global load with nonzero channel field ignored
        cmd2(ins(4'b0001, 0, 2));
        check_wipers("R7 global load ignored");

        // R7 global store into slot 2
        for (int c = 0; c < 4; c++) begin
            cmd3(ins(4'b1010, 0, c), 8'(60 - c * 3));
            ew[c] = 60 - c * 3;
        end
        n0 = nv_cnt;
        cmd2(ins(4'b1000, 2, 0));
        check("R7 store mask", nv_m, 15);
        check("R7 store slot", nv_s, 2);
        for (int c = 0; c < 4; c++) begin
            edr[c][2] = ew[c];
            check("R7 store data", int'(nv_d[c*6 +: 6]), ew[c]);
        end
        n0 = nv_cnt;
        cmd2(ins(4'b1000, 0, 1));
        check("R7 store ignored", nv_cnt - n0, 0);
        for (int c = 0; c < 4; c++) begin
            cmd2(ins(4'b1011, 2, c));
            check("R7 store readback", tx_last, edr[c][2]);
        end

        // R8 status
        wip = 1'b0;
        cmd2(8'h51);
        check("R8 idle", tx_last, 0);
        wip = 1'b1;
        t0 = tx_cnt;
        cmd2(8'h51);
        check("R8 busy", tx_last, 1);
        check("R8 count", tx_cnt - t0, 1);
        wip = 1'b0;

        // R9 stepping with saturation
        cmd3(ins(4'b1010, 0, 1), 8'd61);
        ew[1] = 61;
        open_win(); send(DEVB); send(ins(4'b0010, 0, 1));
        for (int k = 0; k < 4; k++) step(1'b1);
        @(negedge clk);
        ew[1] = 63;
        check_wipers("R9 up saturate");
        for (int k = 0; k < 5; k++) step(1'b0);
        @(negedge clk);
        ew[1] = 58;
        check_wipers("R9 down");
        close_win();
        cmd3(ins(4'b1010, 0, 1), 8'd2);
        ew[1] = 2;
        open_win(); send(DEVB); send(ins(4'b0010, 0, 1));
        for (int k = 0; k < 5; k++) step(1'b0);
        step(1'b1);
        @(negedge clk);
        ew[1] = 1;
        check_wipers("R9 down saturate");
        close_win();
        step(1'b1);
        @(negedge clk);
        check_wipers("R9 mode ends");

        // R10 unknown opcode and extra bytes
        t0 = tx_cnt;
        n0 = nv_cnt;
        open_win(); send(DEVB); send(8'h33); send(8'd9); close_win();
        cmd2(8'h5F);
        check_wipers("R10 unknown");
        check("R10 no read", tx_cnt - t0, 0);
        check("R10 no request", nv_cnt - n0, 0);
        open_win(); send(DEVB); send(ins(4'b1010, 0, 0)); send(8'd20);
        send(8'd40); send(ins(4'b1010, 0, 0)); send(8'd41); close_win();
        ew[0] = 20;
        check_wipers("R10 extra bytes");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule